// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the completion events of eight DMA channels and turns them into one interrupt line for the processor. Each channel reports two kinds of event as one-cycle pulses: a half-transfer event when it has moved half of its current chunk, and a transfer-complete event when the chunk is finished. Every event sets its own pending flag. A flag stays set until software acknowledges it through the register port.

The channels fall into two groups. Four normal channels have their flags in the low half-word of the status and enable registers. Four dedicated channels have theirs in the high half-word. A per-event enable register masks the pending flags. The OR of the masked flags is registered and driven out as the interrupt. Software acknowledges events by writing ones to the status register, so the value just read can be written back unchanged. A third register holds a priority configuration word that other logic consumes; this block only stores it and returns it on a read.

The register port is a simple synchronous write strobe with a combinational read. The byte offset selects the register: 0x00 is the enable register, 0x04 is the pending status register and 0x08 is the priority word.

Top module: `dmairq_ctrl`

## Requirements
- R1: A pulse on `half_evt[i]` for a normal channel i (0..3) sets status bit 2i, and a pulse on `done_evt[i]` sets status bit 2i+1. The bit is set at the clock edge that samples the pulse.
- R2: A pulse on `half_evt[4+j]` for a dedicated channel j (0..3) sets status bit 16+2j, and a pulse on `done_evt[4+j]` sets status bit 17+2j.
- R3: A write to offset 0x04 clears every pending bit that has a 1 in the write data. Bits written with 0 keep their value, and writing 0x00FF00FF clears every flag.
- R4: When an event pulse and a write-one clear hit the same bit in the same cycle, the bit stays pending.
- R5: After reset the enable register, the status register and the priority word read 0, and `irq` is 0. A write to offset 0x00 loads the enable register, which reads back the written value on its defined bits.
- R6: A write to offset 0x08 stores the low 16 bits of the data as the priority word (for example 0x190), and a read of 0x08 returns it zero-extended.
- R7: Bits 8 to 15 and 24 to 31 of the enable and status registers always read 0, and writes to them have no effect.
- R8: `irq` equals the OR over all bits of (status AND enable) as it stood in the previous cycle. The output is one register stage behind the flags.
- R9: A flag still latches while its enable bit is 0. Enabling it later raises `irq` one cycle after the enable write.
- R10: Reads of any other offset return 0, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| half_evt | input | 8 | Half-transfer pulses, index 0..3 normal, 4..7 dedicated |
| done_evt | input | 8 | Transfer-complete pulses, same indexing |
| irq | output | 1 | Combined registered interrupt |

## Verification
The checker module checks these properties on every cycle:
- each event pulse shows up as its pending bit on the next cycle, even when a clear hits the same bit;
- a pending bit never drops without a matching write-one clear;
- the reserved bits stay 0;
- `irq` follows the masked OR of the previous cycle.

The bench checks what only observation through the register port can show, using scenarios and randomized traffic against a reference model:
- the exact bit layout seen by a reader;
- read-back of the enable register and the priority word;
- that writes to undefined offsets change nothing;
- the delayed interrupt after a late enable.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

   localparam int unsigned REG_W   = 32;
   localparam int unsigned HI_BASE = 16;

   localparam logic [3:0] OFF_ENABLE = 4'h0;
   localparam logic [3:0] OFF_STATUS = 4'h4;
   localparam logic [3:0] OFF_PRIO   = 4'h8;

   typedef enum logic [1:0] {
      SEL_ENABLE,
      SEL_STATUS,
      SEL_PRIO,
      SEL_NONE
   } reg_sel_e;

   // Status bit used by the half-transfer event of channel ch
   function automatic int unsigned half_pos(input int unsigned ch,
                                            input int unsigned n_norm);
      if (ch < n_norm) return 2 * ch;
      return HI_BASE + 2 * (ch - n_norm);
   endfunction

   // Complete event sits one bit above the half event
   function automatic int unsigned done_pos(input int unsigned ch,
                                            input int unsigned n_norm);
      return half_pos(ch, n_norm) + 1;
   endfunction

   function automatic logic [REG_W-1:0] defined_mask(input int unsigned n_norm,
                                                     input int unsigned n_ded);
      logic [REG_W-1:0] m;
      m = '0;
      for (int unsigned c = 0; c < n_norm + n_ded; c++) begin
         m[half_pos(c, n_norm)] = 1'b1;
         m[done_pos(c, n_norm)] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/dmairq_evmap.sv
module dmairq_evmap
   import dmairq_pkg::*;
#(
   parameter int unsigned N_NORM = 4,
   parameter int unsigned N_DED  = 4,
   localparam int unsigned N_CH  = N_NORM + N_DED
) (
   input  logic [N_CH-1:0]  half_evt,
   input  logic [N_CH-1:0]  done_evt,
   output logic [REG_W-1:0] set_vec
);

   logic [N_CH-1:0][REG_W-1:0] per_ch;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam int unsigned HP = half_pos(c, N_NORM);
      localparam int unsigned DP = done_pos(c, N_NORM);
      always_comb begin
         per_ch[c]     = '0;
         per_ch[c][HP] = half_evt[c];
         per_ch[c][DP] = done_evt[c];
      end
   end

   always_comb begin
      set_vec = '0;
      for (int unsigned c = 0; c < N_CH; c++) begin
         set_vec = set_vec | per_ch[c];
      end
   end

endmodule

// File: rtl/dmairq_pend.sv
module dmairq_pend
   import dmairq_pkg::*;
#(
   parameter logic [REG_W-1:0] VALID = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_vec,
   input  logic [REG_W-1:0] clr_vec,
   output logic [REG_W-1:0] pend_q
);

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (VALID[b]) begin : g_flop
         // An arriving event outranks an acknowledge of the same bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pend_q[b] <= 1'b0;
            else if (set_vec[b]) pend_q[b] <= 1'b1;
            else if (clr_vec[b]) pend_q[b] <= 1'b0;
         end
      end else begin : g_tie
         assign pend_q[b] = 1'b0;
      end
   end

endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs
   import dmairq_pkg::*;
#(
   parameter int unsigned      ADDR_W = 4,
   parameter int unsigned      PRIO_W = 16,
   parameter logic [REG_W-1:0] VALID  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [REG_W-1:0]  pend_q,
   output logic [REG_W-1:0]  en_q,
   output logic [REG_W-1:0]  clr_vec,
   output logic [REG_W-1:0]  rdata
);

   reg_sel_e          sel;
   logic [PRIO_W-1:0] prio_q;

   always_comb begin
      if      (addr == ADDR_W'(OFF_ENABLE)) sel = SEL_ENABLE;
      else if (addr == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
      else if (addr == ADDR_W'(OFF_PRIO))   sel = SEL_PRIO;
      else                                  sel = SEL_NONE;
   end

   assign clr_vec = (wr_en && sel == SEL_STATUS) ? (wdata & VALID) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         prio_q <= '0;
      end else if (wr_en) begin
         if (sel == SEL_ENABLE) en_q   <= wdata & VALID;
         if (sel == SEL_PRIO)   prio_q <= wdata[PRIO_W-1:0];
      end
   end

   always_comb begin
      unique case (sel)
         SEL_ENABLE: rdata = en_q;
         SEL_STATUS: rdata = pend_q;
         SEL_PRIO:   rdata = REG_W'(prio_q);
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/dmairq_irqout.sv
module dmairq_irqout
   import dmairq_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] pend_q,
   input  logic [REG_W-1:0] en_q,
   output logic             irq
);

   logic any_hit;
   assign any_hit = |(pend_q & en_q);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= any_hit;
      end
   end else begin : g_comb
      // Unused: the clock is not needed without the output flop
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = any_hit;
   end

endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
   import dmairq_pkg::*;
#(
   parameter int unsigned N_NORM  = 4,
   parameter int unsigned N_DED   = 4,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned PRIO_W  = 16,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned N_CH   = N_NORM + N_DED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [N_CH-1:0]   half_evt,
   input  logic [N_CH-1:0]   done_evt,
   output logic              irq
);

   localparam logic [REG_W-1:0] VALID = defined_mask(N_NORM, N_DED);

   if (N_NORM * 2 > HI_BASE) begin : g_chk_norm
      $error("dmairq_ctrl: N_NORM does not fit in the low half-word");
   end
   if (N_DED * 2 > REG_W - HI_BASE) begin : g_chk_ded
      $error("dmairq_ctrl: N_DED does not fit in the high half-word");
   end
   if (ADDR_W < 4) begin : g_chk_addr
      $error("dmairq_ctrl: ADDR_W must reach offset 0x08");
   end
   if (PRIO_W < 1 || PRIO_W > REG_W) begin : g_chk_prio
      $error("dmairq_ctrl: PRIO_W out of range");
   end

   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] clr_vec;
   logic [REG_W-1:0] pend_q;
   logic [REG_W-1:0] en_q;

   dmairq_evmap #(.N_NORM(N_NORM), .N_DED(N_DED)) u_evmap (
      .half_evt (half_evt),
      .done_evt (done_evt),
      .set_vec  (set_vec)
   );

   dmairq_pend #(.VALID(VALID)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .pend_q  (pend_q)
   );

   dmairq_regs #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .VALID(VALID)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .pend_q  (pend_q),
      .en_q    (en_q),
      .clr_vec (clr_vec),
      .rdata   (reg_rdata)
   );

   dmairq_irqout #(.OUT_REG(OUT_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_q (pend_q),
      .en_q   (en_q),
      .irq    (irq)
   );

endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk
   import dmairq_pkg::*;
#(
   parameter int unsigned N_NORM = 4,
   parameter int unsigned N_DED  = 4,
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned N_CH  = N_NORM + N_DED
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [N_CH-1:0]   half_evt,
   input logic [N_CH-1:0]   done_evt,
   input logic [REG_W-1:0]  pend_q,
   input logic [REG_W-1:0]  en_q,
   input logic              irq
);

   localparam logic [REG_W-1:0] VALID = defined_mask(N_NORM, N_DED);

   logic [REG_W-1:0] ack_bits;
   assign ack_bits = (reg_wr_en && reg_addr == ADDR_W'(OFF_STATUS)) ? reg_wdata : '0;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam int unsigned HP = half_pos(c, N_NORM);
      localparam int unsigned DP = done_pos(c, N_NORM);
      if (c < N_NORM) begin : g_norm
         // R1 and R4: normal-channel event reaches its flag even against a clear
         a_r1_half_sets: assert property (@(posedge clk) disable iff (!rst_n)
            half_evt[c] |=> pend_q[HP]);
         a_r1_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
            done_evt[c] |=> pend_q[DP]);
      end else begin : g_ded
         // R2 and R4: dedicated-channel mapping into the high half-word
         a_r2_half_sets: assert property (@(posedge clk) disable iff (!rst_n)
            half_evt[c] |=> pend_q[HP]);
         a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
            done_evt[c] |=> pend_q[DP]);
      end
   end

   // R3: a flag only drops where a one was written to the status register
   a_r3_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_q) & ~$past(ack_bits)) & ~pend_q) == '0));

   // R7: reserved positions never hold a one
   a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q | en_q) & ~VALID) == '0);

   // R8: interrupt tracks the masked flags one cycle later
   a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(pend_q & en_q))));

   // R5: interrupt is low right after reset
   a_r5_irq_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq);

endmodule

bind dmairq_ctrl dmairq_chk #(.N_NORM(N_NORM), .N_DED(N_DED), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr_en (reg_wr_en),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .half_evt  (half_evt),
   .done_evt  (done_evt),
   .pend_q    (pend_q),
   .en_q      (en_q),
   .irq       (irq)
);

// File: tb/tb_dmairq_ctrl.sv
`timescale 1ns/1ps
module tb_dmairq_ctrl;

   localparam logic [31:0] MASK = 32'h00FF_00FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  half_evt = '0;
   logic [7:0]  done_evt = '0;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   logic [31:0] m_en, m_pend;
   logic [15:0] m_prio;
   logic        m_irq;

   always #2.5 clk = ~clk;

   dmairq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .half_evt(half_evt),
      .done_evt(done_evt), .irq(irq)
   );

   function automatic logic [31:0] ev_bits(input logic [7:0] h, input logic [7:0] d);
      logic [31:0] v = '0;
      for (int i = 0; i < 4; i++) begin
         v[2*i]        = h[i];
         v[2*i+1]      = d[i];
         v[16+2*i]     = h[4+i];
         v[17+2*i]     = d[4+i];
      end
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one cycle from a falling edge, update the model at the rising edge
   task automatic cyc(input logic [7:0] h, input logic [7:0] d, input logic wr,
                      input logic [3:0] a, input logic [31:0] wd);
      logic [31:0] clr;
      half_evt = h; done_evt = d; reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
      @(posedge clk);
      m_irq = |(m_pend & m_en);
      clr = (wr && a == 4'h4) ? (wd & MASK) : '0;
      m_pend = ((m_pend & ~clr) | ev_bits(h, d)) & MASK;
      if (wr && a == 4'h0) m_en = wd & MASK;
      if (wr && a == 4'h8) m_prio = wd[15:0];
      @(negedge clk);
      half_evt = '0; done_evt = '0; reg_wr_en = 1'b0;
   endtask

   task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
      reg_addr = a;
      #0.5;
      chk(req, reg_rdata, exp);
   endtask

   task automatic idle();
      cyc('0, '0, 1'b0, 4'h0, '0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_en = '0; m_pend = '0; m_prio = '0; m_irq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: reset state
      rd("R5 enable reset", 4'h0, 32'h0);
      rd("R5 status reset", 4'h4, 32'h0);
      rd("R5 prio reset",   4'h8, 32'h0);
      chk("R5 irq reset", {31'b0, irq}, 32'h0);

      // R1: normal channel mapping, one event at a time
      for (int i = 0; i < 4; i++) begin
         cyc(8'(1 << i), '0, 1'b0, 4'h0, '0);
         rd("R1 half bit", 4'h4, 32'(1) << (2*i));
         cyc('0, 8'(1 << i), 1'b1, 4'h4, 32'h00FF00FF);
         rd("R1 done bit", 4'h4, 32'(1) << (2*i+1));
         cyc('0, '0, 1'b1, 4'h4, 32'h00FF00FF);
      end
      // R2: dedicated channel mapping
      for (int j = 0; j < 4; j++) begin
         cyc(8'(1 << (4+j)), 8'(1 << (4+j)), 1'b0, 4'h0, '0);
         rd("R2 dedicated bits", 4'h4, 32'(3) << (16+2*j));
         cyc('0, '0, 1'b1, 4'h4, 32'h00FF00FF);
      end
      rd("R3 clear all", 4'h4, 32'h0);

      // R3: partial acknowledge leaves zero-written bits set
      cyc(8'hFF, 8'hFF, 1'b0, 4'h0, '0);
      cyc('0, '0, 1'b1, 4'h4, 32'h0003_0005);
      rd("R3 partial clear", 4'h4, 32'h00FC_00FA);

      // R4: set beats simultaneous clear
      cyc(8'h01, '0, 1'b1, 4'h4, 32'h00FF00FF);
      rd("R4 set wins", 4'h4, 32'h0000_0001);
      cyc('0, '0, 1'b1, 4'h4, 32'h1);

      // R7: reserved bits ignore writes and read zero
      cyc('0, '0, 1'b1, 4'h0, 32'hFFFF_FFFF);
      rd("R7 enable reserved", 4'h0, MASK);
      rd("R5 enable readback", 4'h0, m_en);
      cyc('0, '0, 1'b1, 4'h0, 32'h0);

      // R6: priority word
      cyc('0, '0, 1'b1, 4'h8, 32'hABCD_0190);
      rd("R6 prio readback", 4'h8, 32'h0000_0190);

      // R10: undefined offset writes change nothing and read zero
      cyc('0, '0, 1'b1, 4'hC, 32'hFFFF_FFFF);
      rd("R10 undefined read", 4'hC, 32'h0);
      rd("R10 enable untouched", 4'h0, 32'h0);
      rd("R10 prio untouched", 4'h8, 32'h0000_0190);

      // R9: latch while disabled, then enable
      cyc('0, 8'h20, 1'b0, 4'h0, '0);
      rd("R9 latched while masked", 4'h4, 32'h0008_0000);
      chk("R9 irq low while masked", {31'b0, irq}, 32'h0);
      cyc('0, '0, 1'b1, 4'h0, 32'h0008_0000);
      chk("R9 irq waits one cycle", {31'b0, irq}, 32'h0);
      idle();
      chk("R9 irq after enable", {31'b0, irq}, 32'h1);
      cyc('0, '0, 1'b1, 4'h4, 32'h0008_0000);
      idle();
      chk("R8 irq drops after clear", {31'b0, irq}, 32'h0);

      // R8 with R1, R2, R3, R4: randomized traffic against the model
      for (int k = 0; k < 400; k++) begin
         logic [7:0] h, d;
         logic [31:0] r, wd;
         logic wr;
         logic [3:0] a;
         r  = $urandom;
         h  = (r[3:0] == 0) ? 8'($urandom) : '0;
         d  = (r[7:4] == 0) ? 8'($urandom) : '0;
         wr = r[8] & r[9];
         a  = (r[11:10] == 2'd0) ? 4'h0 : (r[11:10] == 2'd1) ? 4'h4 :
              (r[11:10] == 2'd2) ? 4'h8 : 4'h4;
         wd = $urandom;
         cyc(h, d, wr, a, wd);
         chk("R8 random irq", {31'b0, irq}, {31'b0, m_irq});
         if (k % 8 == 0) rd("R3 random status", 4'h4, m_pend);
         if (k % 16 == 0) rd("R5 random enable", 4'h0, m_en);
      end
      rd("R6 final prio", 4'h8, {16'h0, m_prio});

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule